// File: doc/BRIEF.md
# Receive Sampling Tap Window Search

This engine picks the receive sampling delay for an eMMC link running in HS200 timing. When started, it walks a delay tap upward from zero through a fixed number of steps. At each step it presents the tap value and raises an update request. It then waits for the delay line to acknowledge. If the acknowledge arrives, it asks an external checker to run one tuning-block transfer and waits for a pass or fail answer.

While sweeping, the engine tracks the current run of consecutive good taps and the best run found so far. The best run is kept as its length and its last tap. After the last step it programs the middle of the best run through the same update handshake and reports the chosen tap. If no tap was good, or the final update is never acknowledged, it reports an error instead. Issuing the tuning command on the bus belongs to the checker, and timings other than HS200 are handled by other logic.

Top module: `sdtune_window_search`

## Requirements
- R1: After an accepted start, taps 0, 1, … up to TAP_COUNT-1 (default 40, so 0..39) are each presented on `tap_o` exactly once, in ascending order, and each is presented with `tap_req_o` high.
- R2: `tap_req_o` stays high, with `tap_o` held stable, until `tap_ack_i` is seen. If no acknowledge arrives within UPD_TIMEOUT cycles, the request is withdrawn and that tap counts as failing, with no test request issued for it.
- R3: Each acknowledged sweep tap produces exactly one single-cycle `test_req_o` while `tap_req_o` is low. A tap counts as good only if `test_done_i` returns with `test_pass_i` high, and a failing tap resets the current run to zero.
- R4: The best run is replaced only by a strictly longer run, so among equally long runs the one that starts earliest is chosen.
- R5: The final tap equals the last tap of the best run minus floor(run length / 2). It is applied with one more update handshake, and it is reported on `result_o` together with `done_o`.
- R6: If no tap is good, `done_o` pulses with `err_o` high and no final update request is issued.
- R7: If the final update is not acknowledged within UPD_TIMEOUT cycles, `done_o` pulses with `err_o` high.
- R8: `done_o` is a single-cycle pulse issued after the final handshake ends, and `err_o` is only ever high together with `done_o`.
- R9: A start pulse while a search is in progress is ignored: the sweep is neither restarted nor extended.
- R10: A start pulse while `hs200_i` is low is ignored: no tap request and no done follow.
- R11: After reset, `tap_req_o`, `test_req_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a search |
| hs200_i | input | 1 | High when the link is in HS200 timing |
| tap_o | output | TAP_W | Tap value being applied |
| tap_req_o | output | 1 | Tap update request, held until acknowledged or timed out |
| tap_ack_i | input | 1 | Delay line reports the new tap is in effect |
| test_req_o | output | 1 | One-cycle request to run a tuning-block transfer |
| test_done_i | input | 1 | Checker has finished the transfer |
| test_pass_i | input | 1 | Transfer result, valid with test_done_i |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| err_o | output | 1 | Search failed, valid with done_o |
| result_o | output | TAP_W | Chosen tap, valid with done_o when err_o is low |

## Verification
The hardest situation to reach is an update timeout. The delay line has to stay silent on one particular tap, either inside a run of good taps (where the run must split) or on the final program step (where a good sweep must still end in error). The bench's delay-line model holds a per-tap mask of taps it never acknowledges, plus a separate flag for the final step. This lets directed and random cases place timeouts anywhere in the sweep. The model also varies the acknowledge latency, and the expected tap is recomputed in the bench from the masks alone.

// File: rtl/sdtune_pkg.sv
package sdtune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_TEST,
    ST_NEXT,
    ST_FINAL
  } tune_state_e;
endpackage

// File: rtl/sdtune_tap_hs.sv
module sdtune_tap_hs #(
  parameter int TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic ack_i,
  output logic req_o,
  output logic ok_o,
  output logic fail_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      if (go_i) begin
        req_o <= 1'b1;
        cnt_q <= '0;
      end else if (req_o) begin
        if (ack_i) begin
          req_o <= 1'b0;
          ok_o  <= 1'b1;
        end else if (cnt_q == LAST_CNT) begin
          req_o  <= 1'b0;
          fail_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i && !go_i && cnt_q != LAST_CNT) |=> req_o); // R2
  AST_OK_XOR_FAIL: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && fail_o)); // R2
endmodule

// File: rtl/sdtune_streak.sv
module sdtune_streak #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [LEN_W-1:0] best_len_o,
  output logic [TAP_W-1:0] best_end_o
);
  logic [LEN_W-1:0] cur_q;
  logic [LEN_W-1:0] cur_inc;

  assign cur_inc = cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cur_q      <= '0;
      best_len_o <= '0;
      best_end_o <= '0;
    end else if (upd_i) begin
      if (pass_i) begin
        cur_q <= cur_inc;
        if (cur_inc > best_len_o) begin
          best_len_o <= cur_inc;
          best_end_o <= tap_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  AST_BEST_COVERS_CUR: assert property (@(posedge clk) disable iff (rst)
    best_len_o >= cur_q); // R4
  AST_BEST_NONDECR: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> best_len_o >= $past(best_len_o)); // R4
endmodule

// File: rtl/sdtune_window_search.sv
module sdtune_window_search
  import sdtune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int TAP_COUNT   = 40,
  parameter int UPD_TIMEOUT = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             hs200_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_req_o,
  input  logic             tap_ack_i,
  output logic             test_req_o,
  input  logic             test_done_i,
  input  logic             test_pass_i,
  output logic             done_o,
  output logic             err_o,
  output logic [TAP_W-1:0] result_o
);
  localparam int LEN_W = $clog2(TAP_COUNT + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

  tune_state_e      state_q;
  logic [TAP_W-1:0] tap_q;
  logic             hs_go_q, hs_ok, hs_fail;
  logic             st_clr, st_upd, st_pass;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] best_end;
  logic [TAP_W-1:0] centre_tap;

  assign st_clr  = (state_q == ST_IDLE) && start_i && hs200_i;
  assign st_upd  = ((state_q == ST_APPLY) && hs_fail) ||
                   ((state_q == ST_TEST) && test_done_i);
  assign st_pass = (state_q == ST_TEST) && test_pass_i;
  assign centre_tap = best_end - TAP_W'(best_len >> 1);
  assign tap_o = tap_q;

  sdtune_tap_hs #(.TIMEOUT(UPD_TIMEOUT)) u_hs (
    .clk   (clk),
    .rst   (rst),
    .go_i  (hs_go_q),
    .ack_i (tap_ack_i),
    .req_o (tap_req_o),
    .ok_o  (hs_ok),
    .fail_o(hs_fail)
  );

  sdtune_streak #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_streak (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (st_clr),
    .upd_i     (st_upd),
    .pass_i    (st_pass),
    .tap_i     (tap_q),
    .best_len_o(best_len),
    .best_end_o(best_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tap_q      <= '0;
      hs_go_q    <= 1'b0;
      test_req_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      result_o   <= '0;
    end else begin
      hs_go_q    <= 1'b0;
      test_req_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (st_clr) begin
          tap_q   <= '0;
          hs_go_q <= 1'b1;
          state_q <= ST_APPLY;
        end
        ST_APPLY: begin
          if (hs_ok) begin
            test_req_o <= 1'b1;
            state_q    <= ST_TEST;
          end else if (hs_fail) begin
            state_q <= ST_NEXT;
          end
        end
        ST_TEST: if (test_done_i) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (tap_q == LAST_TAP) begin
            if (best_len == '0) begin
              done_o  <= 1'b1;
              err_o   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              tap_q   <= centre_tap;
              hs_go_q <= 1'b1;
              state_q <= ST_FINAL;
            end
          end else begin
            tap_q   <= tap_q + 1'b1;
            hs_go_q <= 1'b1;
            state_q <= ST_APPLY;
          end
        end
        ST_FINAL: begin
          if (hs_ok) begin
            done_o   <= 1'b1;
            result_o <= tap_q;
            state_q  <= ST_IDLE;
          end else if (hs_fail) begin
            done_o  <= 1'b1;
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    tap_req_o |-> (tap_o <= LAST_TAP)); // R1
  AST_TAP_STEADY: assert property (@(posedge clk) disable iff (rst)
    tap_req_o |=> $stable(tap_o)); // R2
  AST_TEST_APART: assert property (@(posedge clk) disable iff (rst)
    test_req_o |-> !tap_req_o); // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !tap_req_o); // R10
endmodule

// File: tb/sdtune_window_search_tb.sv
module sdtune_window_search_tb;
  localparam int TAP_W = 6;
  localparam int N     = 40;
  localparam int TO    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, hs200_i = 1'b0;
  logic [TAP_W-1:0] tap_o, result_o;
  logic tap_req_o, test_req_o, done_o, err_o;
  logic tap_ack_i = 1'b0, test_done_i = 1'b0, test_pass_i = 1'b0;

  int checks = 0, failures = 0, cycles = 0;

  logic [63:0] pass_m, noack_m;
  logic        final_noack;
  int          lat;
  int          apps, tests, exp_final;
  logic        seq_ok, seen;
  int          wcnt, tcnt;
  logic [TAP_W-1:0] ttap;

  always #2.5 clk = ~clk;

  sdtune_window_search #(.TAP_W(TAP_W), .TAP_COUNT(N), .UPD_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .hs200_i(hs200_i),
    .tap_o(tap_o), .tap_req_o(tap_req_o), .tap_ack_i(tap_ack_i),
    .test_req_o(test_req_o), .test_done_i(test_done_i), .test_pass_i(test_pass_i),
    .done_o(done_o), .err_o(err_o), .result_o(result_o)
  );

  // delay-line model
  always @(negedge clk) begin
    cycles = cycles + 1;
    tap_ack_i = 1'b0;
    if (!tap_req_o) seen = 1'b0;
    else if (!seen) begin
      seen = 1'b1;
      wcnt = lat;
      if (apps < N) begin if (int'(tap_o) != apps) seq_ok = 1'b0; end
      else if (apps == N) begin if (int'(tap_o) != exp_final) seq_ok = 1'b0; end
      else seq_ok = 1'b0;
      apps = apps + 1;
    end else if (wcnt > 0) wcnt = wcnt - 1;
    else if (!((apps <= N) ? noack_m[tap_o] : final_noack)) tap_ack_i = 1'b1;
  end

  // tuning checker model
  always @(negedge clk) begin
    test_done_i = 1'b0;
    if (tcnt > 0) begin
      tcnt = tcnt - 1;
      if (tcnt == 0) begin test_done_i = 1'b1; test_pass_i = pass_m[ttap]; end
    end
    if (test_req_o) begin tests = tests + 1; ttap = tap_o; tcnt = 2; end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] p, input logic [63:0] na,
                       output logic e_err, output int e_res, output int e_tests);
    int cur = 0, best = 0, bend = 0;
    e_tests = 0;
    for (int i = 0; i < N; i++) begin
      if (!na[i]) e_tests++;
      if (p[i] && !na[i]) begin
        cur++;
        if (cur > best) begin best = cur; bend = i; end
      end else cur = 0;
    end
    e_err = (best == 0);
    e_res = bend - best / 2;
  endtask

  task automatic run_case(input logic [63:0] p, input logic [63:0] na,
                          input logic fna, input int l, input logic busy_start,
                          input string tag);
    logic e_err, got_err;
    int e_res, e_tests, got_res, w;
    logic got;
    model(p, na, e_err, e_res, e_tests);
    if (fna) e_err = 1'b1;
    pass_m = p; noack_m = na; final_noack = fna; lat = l;
    apps = 0; tests = 0; seq_ok = 1'b1; exp_final = e_res;
    @(negedge clk); start_i = 1'b1; hs200_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    got = 1'b0; w = 0; got_err = 1'b0; got_res = 0;
    while (!got && w < 20000) begin
      @(negedge clk); w++;
      if (busy_start && w == 30) start_i = 1'b1;
      else start_i = 1'b0;
      if (done_o) begin got = 1'b1; got_err = err_o; got_res = int'(result_o); end
    end
    start_i = 1'b0;
    chk(got, {tag, " R8 done seen"}, int'(got), 1);
    chk(got_err == e_err, {tag, " R6/R7 err"}, int'(got_err), int'(e_err));
    if (!e_err) chk(got_res == e_res, {tag, " R5 result"}, got_res, e_res);
    chk(seq_ok, {tag, " R1 tap order"}, int'(seq_ok), 1);
    chk(apps == ((p & ~na & ((64'd1 << N) - 1)) == 0 ? N : N + 1),
        {tag, " R9 application count"}, apps,
        ((p & ~na & ((64'd1 << N) - 1)) == 0 ? N : N + 1));
    chk(tests == e_tests, {tag, " R2/R3 test count"}, tests, e_tests);
    @(negedge clk);
    chk(!done_o && !err_o, {tag, " R8 single pulse"}, int'(done_o), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] rp, rn;
    int hits;
    seen = 1'b0; wcnt = 0; tcnt = 0; ttap = '0; apps = 0; tests = 0;
    seq_ok = 1'b1; pass_m = '0; noack_m = '0; final_noack = 1'b0; lat = 1; exp_final = 0;
    repeat (4) @(negedge clk);
    chk(!tap_req_o, "R11 tap_req reset", int'(tap_req_o), 0);
    chk(!test_req_o, "R11 test_req reset", int'(test_req_o), 0);
    chk(!done_o, "R11 done reset", int'(done_o), 0);
    chk(!err_o, "R11 err reset", int'(err_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: start ignored outside HS200
    hs200_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    hits = 0;
    repeat (40) begin @(negedge clk); if (tap_req_o || done_o) hits++; end
    chk(hits == 0 && apps == 0, "R10 no activity without hs200", hits, 0);

    run_case(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1, 1'b0, "all-pass");
    run_case(64'd0, 64'd0, 1'b0, 2, 1'b0, "R6 none-pass");
    run_case(64'h0000_0000_0000_7C7C, 64'd0, 1'b0, 0, 1'b0, "R4 equal-runs");
    run_case(64'h0000_0000_3FF0_001C, 64'd0, 1'b0, 3, 1'b0, "R4 later-longer");
    run_case(64'h0000_0080_0000_0000, 64'd0, 1'b0, 1, 1'b0, "R5 last-tap-only");
    run_case(64'h0000_0000_0000_000F, 64'd0, 1'b0, 2, 1'b0, "R5 even-length");
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_8000, 1'b0, 1, 1'b0, "R2 timeout-split");
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1, 1'b0, "R7 final-timeout");
    run_case(64'h0000_00F0_0F00_0000, 64'd0, 1'b0, 2, 1'b1, "R9 busy-start");
    for (int k = 0; k < 6; k++) begin
      rp = {$urandom, $urandom};
      rn = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      run_case(rp | (rp << 1), rn, 1'b0, k % 4, 1'b0, "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule